// File: doc/BRIEF.md
# SPI Flash Status-Register Write Guard

This block is the instruction-decode and status-register part of a serial flash slave on a mode-0 SPI bus, limited to the two instructions that arm and perform status-register writes. It oversamples chip select, serial clock and serial data in on a fast system clock, counts the bits of each chip-select frame, and acts on a frame only when chip select rises after exactly the number of bits the instruction calls for. Bits are sampled on rising serial-clock edges, most significant bit first.

The status register holds a write-enable latch, three block-protect bits and a write-lock bit. A register write is accepted or refused by combining the write-enable latch, the write-lock bit and the current level of an active-low write-protect pin. When the write-lock bit is 1 and the pin is low the block is in hardware-locked mode. This mode follows the level of both the bit and the pin, so the order in which they change does not matter. Array-protection logic elsewhere reads the register value and the lock flag from the outputs. The serial data output is never driven by this block.

Top module: `spi_sr_protect`

## Requirements
- R1: After reset the status output is 0x00 and hw_locked is 0.
- R2: A frame of exactly 8 bits with opcode 0x06 sets the write-enable latch, which is status bit 1. This happens whatever the lock state.
- R3: A frame of exactly 16 bits with opcode 0x01 followed by a data byte is a register write. When it is accepted, status bit 7 (write-lock) takes data bit 7 and status bits 4..2 (block-protect) take data bits 4..2. Data bits 6, 5, 1 and 0 are ignored, and status bits 6, 5 and 0 always read 0.
- R4: A register write is refused, with no status change, when the write-enable latch is 0.
- R5: When the write-lock bit is 0, a register write with the latch set is accepted at either level of the write-protect pin.
- R6: When the write-lock bit is 1 and the write-protect pin is high, a register write with the latch set is accepted.
- R7: When the write-lock bit is 1 and the write-protect pin is low, every register write is refused, and the status, including the latch, is left unchanged.
- R8: hw_locked is 1 exactly when the write-lock bit is 1 and the pin is low. It is reached by setting the bit with the pin already low, or by pulling the pin low after the bit is set. It is left only by driving the pin high.
- R9: An accepted register write clears the write-enable latch.
- R10: A frame with a bit count other than 8 for opcode 0x06 or 16 for opcode 0x01 (for example 7, 9, 15 or 17 bits), or with any other opcode, changes nothing.
- R11: The serial data output enable so_en stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| status_q | output | 8 | Current status register value |
| hw_locked | output | 1 | Hardware-locked mode flag |
| so_en | output | 1 | Serial data out drive enable, held 0 |
| so_data | output | 1 | Serial data out value, held 0 |

## Verification
Two things can happen in the same cycle: the pin-driven lock changes state, and a register write is judged against that lock. The bench provokes this by entering lock in both orders, first setting the write-lock bit with the pin already low and then pulling the pin low under a bit that is already set. In each case it then sends a write with the latch armed. The scoreboard expects the write to be refused and the latch to stay set. After the pin is released, the same write must be accepted and must clear the latch.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int OP_BITS   = 8;
    localparam int DATA_BITS = 8;
    localparam int FRAME_MAX = OP_BITS + DATA_BITS;
    localparam int CNT_W     = $clog2(FRAME_MAX + 2);

    localparam logic [OP_BITS-1:0] OP_ARM   = 8'h06;
    localparam logic [OP_BITS-1:0] OP_WRREG = 8'h01;

    localparam int POS_LOCK = 7;
    localparam int POS_BP_H = 4;
    localparam int POS_BP_L = 2;
    localparam int POS_WEL  = 1;

    typedef struct packed {
        logic                 valid;
        logic [CNT_W-1:0]     nbits;
        logic [FRAME_MAX-1:0] word;
    } frame_t;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
        logic       wel;
    } sreg_t;

    function automatic logic [DATA_BITS-1:0] sreg_pack(input sreg_t s);
        logic [DATA_BITS-1:0] v;
        v = '0;
        v[POS_LOCK]          = s.lock;
        v[POS_BP_H:POS_BP_L] = s.bp;
        v[POS_WEL]           = s.wel;
        return v;
    endfunction

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sfp_frame.sv
module sfp_frame
    import sfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n_s,
    input  logic   sck_s,
    input  logic   mosi_s,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_MAX + 1);

    logic                 sck_d;
    logic                 cs_d;
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
            shreg <= '0;
            cnt   <= '0;
            frame <= '0;
        end else begin
            sck_d       <= sck_s;
            cs_d        <= cs_n_s;
            frame.valid <= 1'b0;
            if (cs_n_s) begin
                if (!cs_d) begin
                    frame.valid <= 1'b1;
                    frame.nbits <= cnt;
                    frame.word  <= shreg;
                end
                cnt <= '0;
            end else if (sck_s && !sck_d) begin
                shreg <= {shreg[FRAME_MAX-2:0], mosi_s};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfp_status.sv
module sfp_status
    import sfp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  frame_t               frame,
    input  logic                 wp_n_s,
    output logic [DATA_BITS-1:0] status_q,
    output logic                 hw_locked
);
    sreg_t sreg;
    logic  is_arm;
    logic  is_wrreg;
    logic  wr_ok;
    logic [DATA_BITS-1:0] wdata;

    assign wdata    = frame.word[DATA_BITS-1:0];
    assign is_arm   = frame.valid && (frame.nbits == CNT_W'(OP_BITS))
                      && (frame.word[OP_BITS-1:0] == OP_ARM);
    assign is_wrreg = frame.valid && (frame.nbits == CNT_W'(FRAME_MAX))
                      && (frame.word[FRAME_MAX-1 -: OP_BITS] == OP_WRREG);
    assign hw_locked = sreg.lock && !wp_n_s;
    assign wr_ok     = is_wrreg && sreg.wel && !hw_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (is_arm) begin
            sreg.wel <= 1'b1;
        end else if (wr_ok) begin
            sreg.lock <= wdata[POS_LOCK];
            sreg.bp   <= wdata[POS_BP_H:POS_BP_L];
            sreg.wel  <= 1'b0;
        end
    end

    assign status_q = sreg_pack(sreg);
endmodule

// File: rtl/spi_sr_protect.sv
module spi_sr_protect
    import sfp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    input  logic       wp_n,
    output logic [7:0] status_q,
    output logic       hw_locked,
    output logic       so_en,
    output logic       so_data
);
    logic [3:0] pins_s;
    frame_t     frame_w;
    logic       frame_done;

    sfp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_mosi, wp_n}),
        .q   (pins_s)
    );

    sfp_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (pins_s[3]),
        .sck_s  (pins_s[2]),
        .mosi_s (pins_s[1]),
        .frame  (frame_w)
    );

    sfp_status u_status (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame_w),
        .wp_n_s    (pins_s[0]),
        .status_q  (status_q),
        .hw_locked (hw_locked)
    );

    assign frame_done = frame_w.valid;
    assign so_en      = 1'b0;
    assign so_data    = 1'b0;
endmodule

// File: rtl/spi_sr_protect_chk.sv
module spi_sr_protect_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status_q,
    input logic       hw_locked,
    input logic       so_en,
    input logic       frame_done
);
    // R11
    p_so_hiz_r11: assert property (@(posedge clk) disable iff (rst) !so_en);

    // R3: unused bits read 0
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (status_q[6:5] == 2'b00) && !status_q[0]);

    // R7: while locked, lock and protect bits cannot change
    p_locked_hold_r7: assert property (@(posedge clk) disable iff (rst)
        hw_locked |=> $stable(status_q[7:2]));

    // R8: lock flag needs the lock bit
    p_lock_needs_bit_r8: assert property (@(posedge clk) disable iff (rst)
        hw_locked |-> status_q[7]);

    // R2: latch rises only after a completed frame
    p_wel_after_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[1]) |-> $past(frame_done));

    // R4: lock bit changes only with the latch set beforehand
    p_write_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q[7]) |-> $past(status_q[1]));

    // R9: an accepted write clears the latch
    p_wel_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q[4:2]) |-> !status_q[1]);
endmodule

bind spi_sr_protect spi_sr_protect_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .status_q   (status_q),
    .hw_locked  (hw_locked),
    .so_en      (so_en),
    .frame_done (frame_done)
);

// File: tb/spi_sr_protect_tb_top.sv
module spi_sr_protect_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       wp_n = 1'b1;
    logic [7:0] status_q;
    logic       hw_locked;
    logic       so_en;
    logic       so_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic       hw;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    spi_sr_protect dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .wp_n(wp_n), .status_q(status_q),
        .hw_locked(hw_locked), .so_en(so_en), .so_data(so_data)
    );

    task automatic xfer(input logic [31:0] bits, input int n);
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = bits[i];
            repeat (4) @(negedge clk);
            spi_sck = 1'b1;
            repeat (4) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        wp_n = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input logic [7:0] st, input logic hw);
        exp_t e;
        e.tag = tag; e.st = st; e.hw = hw;
        sb_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (status_q !== e.st) begin
                    errors++;
                    $display("FAIL %s status actual %h expected %h", e.tag, status_q, e.st);
                end
                checks++;
                if (hw_locked !== e.hw) begin
                    errors++;
                    $display("FAIL %s hw_locked actual %b expected %b", e.tag, hw_locked, e.hw);
                end
                checks++;
                if (so_en !== 1'b0) begin
                    errors++;
                    $display("FAIL R11 so_en actual %b expected 0", so_en);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        expect_state("R1", 8'h00, 1'b0);
        xfer(32'h019C, 16);            expect_state("R4", 8'h00, 1'b0);
        xfer({23'h0, 9'h00C}, 9);      expect_state("R10", 8'h00, 1'b0);
        xfer(32'h03, 7);               expect_state("R10", 8'h00, 1'b0);
        xfer(32'h06, 8);               expect_state("R2", 8'h02, 1'b0);
        set_pin(1'b0);
        xfer(32'h01FF, 16);            expect_state("R5 R3 R9 R8", 8'h9C, 1'b1);
        xfer(32'h06, 8);               expect_state("R2", 8'h9E, 1'b1);
        xfer(32'h0100, 16);            expect_state("R7", 8'h9E, 1'b1);
        xfer(32'h0080, 15);            expect_state("R10", 8'h9E, 1'b1);
        set_pin(1'b1);                 expect_state("R8", 8'h9E, 1'b0);
        xfer(32'h0184, 16);            expect_state("R6", 8'h84, 1'b0);
        set_pin(1'b0);                 expect_state("R8", 8'h84, 1'b1);
        xfer(32'h06, 8);               expect_state("R2", 8'h86, 1'b1);
        xfer(32'h0100, 16);            expect_state("R7", 8'h86, 1'b1);
        set_pin(1'b1);
        xfer(32'h0108, 16);            expect_state("R6 R9", 8'h08, 1'b0);
        set_pin(1'b0);                 expect_state("R8", 8'h08, 1'b0);
        xfer(32'h06, 8);
        xfer(32'h0118, 16);            expect_state("R5", 8'h18, 1'b0);
        xfer(32'h06, 8);               expect_state("R2", 8'h1A, 1'b0);
        xfer(32'h05, 8);               expect_state("R10", 8'h1A, 1'b0);
        xfer({15'h0, 17'h003E3}, 17);  expect_state("R10", 8'h1A, 1'b0);
        xfer(32'h0663, 16);            expect_state("R10", 8'h1A, 1'b0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule